// File: doc/BRIEF.md
# Clock Reprogramming Control Register

This block is a byte-wide control register for a host bridge, together with the sequencing logic that runs when software changes the memory and graphics clock speeds. Software stops the clocks it is about to retune, holds the clock dividers in reset while new frequency settings pass through, then releases the dividers. The release produces a single resynchronize request to the clock generator. After that, software restarts the clocks. The clock generator, the dividers and the clock gates are outside the block. It drives them through level and pulse outputs.

The same register also enables integrated graphics. A propagate command samples an external graphics-disable strap. The sampled value decides which of two configuration functions is visible: the external-port bridge or the graphics device. It also decides whether the graphics clock runs. Once propagation has happened, a release command takes the graphics logic out of reset, and only a hardware reset can put it back. Commands written out of order are ignored or tolerated as the rules below state, and they set a sticky error flag that software can see.

Top module: `clkprog_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, with no write yet, all outputs are 0 except `bridge_cfg_vis`, which is 1. In particular `gfx_rst_n` is 0 and `rd_data` reads 00h.
- R2: With `addr` equal to `REG_ADDR`, `rd_data` returns the register in this layout: bits 7:5 always 0, bit 4 the memory/DLL clock gate, bit 3 the graphics release state, bit 2 the stored propagate bit, bit 1 the stored sync bit, and bit 0 the graphics/memory clock gate. A write with `wr_en` high and any other `addr` changes nothing.
- R3: From the cycle after a write, `dll_clk_gate` equals written bit 4 and `gm_clk_gate` equals written bit 0. A value of 1 means the clocks are stopped.
- R4: `div_reset` equals the stored sync bit (bit 1). On every clock edge where `div_reset` is high, `applied_cfg` loads `pending_cfg`. Otherwise `applied_cfg` holds its value.
- R5: `sync_req` is high for exactly one cycle after a write that moves the stored sync bit from 1 to 0. It stays low after a write of 1 and after a write of 0 while the bit is already 0.
- R6: `seq_err` becomes 1, and stays 1 until hardware reset, after any write that changes the sync bit while either stored gate bit (bit 4 or bit 0) is 0.
- R7: A write with bit 2 = 1 samples `gfx_disable_in`. If it samples 0, then `gfx_cfg_vis` = 1, `gfx_clk_en` = 1 and `bridge_cfg_vis` = 0. If it samples 1, the opposite holds. A write with bit 2 = 0 leaves these outputs unchanged, whatever `gfx_disable_in` is.
- R8: A write with bit 3 = 1, after an earlier write has propagated (bit 2 = 1), sets `gfx_rst_n` to 1. It then stays 1, and bit 3 reads back 1, through any later writes until hardware reset.
- R9: A write with bit 3 = 1 before any earlier propagation leaves `gfx_rst_n` at 0 and sets `seq_err`. This includes a write that sets bits 2 and 3 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for register writes and all outputs |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when `addr` does not match |
| gfx_disable_in | input | 1 | Graphics-disable strap, sampled on propagation |
| pending_cfg | input | CFG_W | New memory-frequency/clock-test settings |
| applied_cfg | output | CFG_W | Settings passed to the clock generator |
| dll_clk_gate | output | 1 | Stop memory and memory-I/O clocks from the DLL |
| gm_clk_gate | output | 1 | Stop graphics and memory clocks |
| div_reset | output | 1 | Hold clock dividers in reset |
| sync_req | output | 1 | One-cycle resynchronize request |
| gfx_clk_en | output | 1 | Graphics clock enable |
| gfx_cfg_vis | output | 1 | Graphics configuration function visible |
| bridge_cfg_vis | output | 1 | Bridge configuration function visible |
| gfx_rst_n | output | 1 | Graphics reset, 1 = released |
| seq_err | output | 1 | Sticky write-order error |

## Verification
The bench builds the block with its defaults: an 8-bit address, register offset 3Ch, a 4-bit settings field and the combinational read path. With the combinational path, the readback is visible in the same cycle as the action outputs, so one scoreboard entry covers both. Using the neighbouring offset 3Dh makes the mismatched-address write case easy to reach. The 4-bit settings width lets distinct values show whether `applied_cfg` loaded during the divider-reset window or held outside it.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;
   localparam int REG_W  = 8;
   localparam int B_GM   = 0;
   localparam int B_SYNC = 1;
   localparam int B_PROP = 2;
   localparam int B_REL  = 3;
   localparam int B_DLL  = 4;

   typedef struct packed {
      logic dll_gate;
      logic release_gfx;
      logic propagate;
      logic sync;
      logic gm_gate;
   } ctl_fields_t;

   function automatic ctl_fields_t split_fields(input logic [REG_W-1:0] d);
      ctl_fields_t f;
      f.dll_gate    = d[B_DLL];
      f.release_gfx = d[B_REL];
      f.propagate   = d[B_PROP];
      f.sync        = d[B_SYNC];
      f.gm_gate     = d[B_GM];
      return f;
   endfunction
endpackage

// File: rtl/clkprog_gate_seq.sv
module clkprog_gate_seq
   import clkprog_pkg::*;
#(
   parameter int CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  ctl_fields_t      wf,
   input  logic [CFG_W-1:0] pending_cfg,
   output logic             dll_gate,
   output logic             gm_gate,
   output logic             div_reset,
   output logic             sync_req,
   output logic             err_set,
   output logic [CFG_W-1:0] applied_cfg
);
   logic gates_closed;
   logic sync_fall;
   logic sync_change;

   assign gates_closed = dll_gate & gm_gate;
   assign sync_fall    = wr_stb & div_reset & ~wf.sync;
   assign sync_change  = wr_stb & (div_reset ^ wf.sync);
   assign err_set      = sync_change & ~gates_closed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dll_gate    <= 1'b0;
         gm_gate     <= 1'b0;
         div_reset   <= 1'b0;
         sync_req    <= 1'b0;
         applied_cfg <= '0;
      end else begin
         sync_req <= sync_fall;
         if (wr_stb) begin
            dll_gate  <= wf.dll_gate;
            gm_gate   <= wf.gm_gate;
            div_reset <= wf.sync;
         end
         if (div_reset) applied_cfg <= pending_cfg;
      end
   end
endmodule

// File: rtl/clkprog_gfx_ctrl.sv
module clkprog_gfx_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic prop_wr,
   input  logic rel_wr,
   input  logic gfx_disable_in,
   output logic prop_bit,
   output logic prop_done,
   output logic gfx_en,
   output logic released,
   output logic err_set
);
   assign err_set = wr_stb & rel_wr & ~prop_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prop_bit  <= 1'b0;
         prop_done <= 1'b0;
         gfx_en    <= 1'b0;
         released  <= 1'b0;
      end else if (wr_stb) begin
         prop_bit <= prop_wr;
         if (prop_wr) begin
            prop_done <= 1'b1;
            gfx_en    <= ~gfx_disable_in;
         end
         if (rel_wr && prop_done) released <= 1'b1;
      end
   end
endmodule

// File: rtl/clkprog_ctrl.sv
module clkprog_ctrl
   import clkprog_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int unsigned REG_ADDR = 'h3C,
   parameter int          CFG_W    = 4,
   parameter bit          RD_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              gfx_disable_in,
   input  logic [CFG_W-1:0]  pending_cfg,
   output logic [CFG_W-1:0]  applied_cfg,
   output logic              dll_clk_gate,
   output logic              gm_clk_gate,
   output logic              div_reset,
   output logic              sync_req,
   output logic              gfx_clk_en,
   output logic              gfx_cfg_vis,
   output logic              bridge_cfg_vis,
   output logic              gfx_rst_n,
   output logic              seq_err
);
   localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("clkprog_ctrl: ADDR_W out of range");
   end
   if (ADDR_W < 32 && REG_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_reg_addr
      $error("clkprog_ctrl: REG_ADDR does not fit ADDR_W");
   end
   if (CFG_W < 1) begin : g_bad_cfg_w
      $error("clkprog_ctrl: CFG_W must be at least 1");
   end

   logic        sel;
   logic        wr_stb;
   ctl_fields_t wf;
   logic        err_sync;
   logic        err_rel;
   logic        prop_bit;
   logic        prop_done;
   logic        gfx_en;
   logic        released;
   logic [REG_W-1:0] reg_view;

   assign sel    = (addr == MATCH);
   assign wr_stb = wr_en & sel;
   assign wf     = split_fields(wr_data);

   clkprog_gate_seq #(.CFG_W(CFG_W)) u_gate_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .wf          (wf),
      .pending_cfg (pending_cfg),
      .dll_gate    (dll_clk_gate),
      .gm_gate     (gm_clk_gate),
      .div_reset   (div_reset),
      .sync_req    (sync_req),
      .err_set     (err_sync),
      .applied_cfg (applied_cfg)
   );

   clkprog_gfx_ctrl u_gfx_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_stb         (wr_stb),
      .prop_wr        (wf.propagate),
      .rel_wr         (wf.release_gfx),
      .gfx_disable_in (gfx_disable_in),
      .prop_bit       (prop_bit),
      .prop_done      (prop_done),
      .gfx_en         (gfx_en),
      .released       (released),
      .err_set        (err_rel)
   );

   assign gfx_clk_en     = gfx_en;
   assign gfx_cfg_vis    = gfx_en;
   assign bridge_cfg_vis = ~gfx_en;
   assign gfx_rst_n      = released;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seq_err <= 1'b0;
      else if (err_sync || err_rel)  seq_err <= 1'b1;
   end

   always_comb begin
      reg_view         = '0;
      reg_view[B_DLL]  = dll_clk_gate;
      reg_view[B_REL]  = released;
      reg_view[B_PROP] = prop_bit;
      reg_view[B_SYNC] = div_reset;
      reg_view[B_GM]   = gm_clk_gate;
   end

   if (RD_REG) begin : g_rd_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= sel ? reg_view : '0;
      end
   end else begin : g_rd_comb
      assign rd_data = sel ? reg_view : '0;
   end
endmodule

// File: rtl/clkprog_ctrl_chk.sv
module clkprog_ctrl_chk #(
   parameter int CFG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_req,
   input logic             div_reset,
   input logic             seq_err,
   input logic             gfx_rst_n,
   input logic             gfx_cfg_vis,
   input logic             bridge_cfg_vis,
   input logic             prop_done,
   input logic [CFG_W-1:0] applied_cfg
);
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> !sync_req);

   a_r5_pulse_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |-> (!div_reset && $past(div_reset)));

   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);

   a_r8_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      gfx_rst_n |=> gfx_rst_n);

   a_r9_release_after_prop: assert property (@(posedge clk) disable iff (!rst_n)
      gfx_rst_n |-> prop_done);

   a_r7_one_function_visible: assert property (@(posedge clk) disable iff (!rst_n)
      gfx_cfg_vis != bridge_cfg_vis);

   a_r4_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(div_reset) |-> $stable(applied_cfg));
endmodule

bind clkprog_ctrl clkprog_ctrl_chk #(.CFG_W(CFG_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .sync_req       (sync_req),
   .div_reset      (div_reset),
   .seq_err        (seq_err),
   .gfx_rst_n      (gfx_rst_n),
   .gfx_cfg_vis    (gfx_cfg_vis),
   .bridge_cfg_vis (bridge_cfg_vis),
   .prop_done      (prop_done),
   .applied_cfg    (applied_cfg)
);

// File: tb/clkprog_ctrl_bench.sv
module clkprog_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 8;
   localparam int unsigned REG_ADDR = 'h3C;
   localparam int CFG_W = 4;
   localparam int VW = CFG_W + 8 + 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = ADDR_W'(REG_ADDR);
   logic              wr_en = 1'b0;
   logic [7:0]        wr_data = '0;
   logic [7:0]        rd_data;
   logic              gfx_dis = 1'b1;
   logic [CFG_W-1:0]  pend = '0;
   logic [CFG_W-1:0]  applied_cfg;
   logic dll_clk_gate, gm_clk_gate, div_reset, sync_req;
   logic gfx_clk_en, gfx_cfg_vis, bridge_cfg_vis, gfx_rst_n, seq_err;

   clkprog_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .CFG_W(CFG_W)) u_clkprog_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .gfx_disable_in(gfx_dis), .pending_cfg(pend),
      .applied_cfg(applied_cfg), .dll_clk_gate(dll_clk_gate), .gm_clk_gate(gm_clk_gate),
      .div_reset(div_reset), .sync_req(sync_req), .gfx_clk_en(gfx_clk_en),
      .gfx_cfg_vis(gfx_cfg_vis), .bridge_cfg_vis(bridge_cfg_vis),
      .gfx_rst_n(gfx_rst_n), .seq_err(seq_err)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int           due;
      string        tag;
      logic [VW-1:0] v;
   } item_t;
   item_t q[$];

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // reference model state
   logic m_dll, m_gm, m_sync, m_prop, m_pdone, m_gen, m_rel, m_err;
   logic [CFG_W-1:0] m_app;

   function automatic logic [VW-1:0] model_vec(input logic pulse, input logic rd_vis);
      logic [7:0] rd;
      rd = rd_vis ? {3'b000, m_dll, m_rel, m_prop, m_sync, m_gm} : 8'h00;
      return {m_app, rd, m_err, m_rel, m_gen, m_gen, ~m_gen, pulse, m_sync, m_dll, m_gm};
   endfunction

   function automatic logic [VW-1:0] dut_vec();
      return {applied_cfg, rd_data, seq_err, gfx_rst_n, gfx_clk_en, gfx_cfg_vis,
              bridge_cfg_vis, sync_req, div_reset, dll_clk_gate, gm_clk_gate};
   endfunction

   task automatic compare(input string tag, input logic [VW-1:0] exp);
      logic [VW-1:0] got;
      got = dut_vec();
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // monitor: pops scoreboard items as their cycle comes due
   always @(posedge clk) begin
      cyc++;
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
         item_t it;
         it = q.pop_front();
         compare(it.tag, it.v);
      end
   end

   task automatic model_reset();
      m_dll = 0; m_gm = 0; m_sync = 0; m_prop = 0;
      m_pdone = 0; m_gen = 0; m_rel = 0; m_err = 0; m_app = '0;
   endtask

   task automatic hw_reset(input string tag);
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      #1;
      compare({tag, " R1 during reset"}, model_vec(1'b0, 1'b1));
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare({tag, " R1 after reset"}, model_vec(1'b0, 1'b1));
   endtask

   // driver: applies one write and pushes the expected outputs
   task automatic wr(input logic [7:0] d, input logic wrong, input string tag);
      logic old_sync;
      logic pulse;
      item_t it;
      @(negedge clk);
      addr    = wrong ? ADDR_W'(REG_ADDR ^ 1) : ADDR_W'(REG_ADDR);
      wr_data = d;
      wr_en   = 1'b1;
      old_sync = m_sync;
      pulse = 1'b0;
      if (!wrong) begin
         if (d[1] != m_sync && !(m_dll && m_gm)) m_err = 1'b1;
         if (d[3] && !m_pdone) m_err = 1'b1;
         if (d[3] && m_pdone) m_rel = 1'b1;
         if (d[2]) begin m_pdone = 1'b1; m_gen = ~gfx_dis; end
         pulse = old_sync && !d[1];
         m_dll = d[4]; m_gm = d[0]; m_sync = d[1]; m_prop = d[2];
      end
      if (old_sync) m_app = pend;
      it.due = cyc + 1; it.tag = {tag, " (write cycle)"}; it.v = model_vec(pulse, !wrong);
      q.push_back(it);
      if (m_sync) m_app = pend;
      it.due = cyc + 2; it.tag = {tag, " (next cycle)"}; it.v = model_vec(1'b0, 1'b1);
      q.push_back(it);
      @(negedge clk);
      wr_en = 1'b0;
      addr  = ADDR_W'(REG_ADDR);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      model_reset();
      #1;
      compare("R1 at time zero", model_vec(1'b0, 1'b1));
      hw_reset("start");

      // full clean reprogramming sequence
      pend = 4'h5;
      wr(8'h11, 1'b0, "R3 close both gates");
      wr(8'h13, 1'b0, "R4 divider reset, settings load");
      wr(8'h13, 1'b0, "R5 sync held at 1, no pulse");
      wr(8'h11, 1'b0, "R5 sync 1->0 single pulse, R6 no error");
      wr(8'h11, 1'b0, "R5 sync 0 again, no pulse");
      wr(8'h00, 1'b0, "R3 reopen gates");
      pend = 4'hA;
      wr(8'h00, 1'b0, "R4 settings hold outside divider reset");
      wr(8'h1F, 1'b1, "R2 write to other address ignored");
      wr(8'hE0, 1'b0, "R2 reserved bits read zero");

      // graphics propagation and release
      gfx_dis = 1'b1;
      wr(8'h04, 1'b0, "R7 propagate with graphics disabled");
      gfx_dis = 1'b0;
      wr(8'h00, 1'b0, "R7 propagate bit 0 ignored");
      wr(8'h04, 1'b0, "R7 propagate with graphics enabled");
      gfx_dis = 1'b1;
      wr(8'h00, 1'b0, "R7 strap change without propagation ignored");
      wr(8'h08, 1'b0, "R8 graphics release");
      wr(8'h00, 1'b0, "R8 release survives write of 0");
      wr(8'h04, 1'b0, "R8 release survives repropagation");

      // release before propagation
      hw_reset("R9 phase");
      wr(8'h08, 1'b0, "R9 release before propagation");
      hw_reset("R9 phase b");
      wr(8'h0C, 1'b0, "R9 release together with propagation");

      // sync without both gates
      hw_reset("R6 phase");
      wr(8'h10, 1'b0, "R3 only DLL gate closed");
      wr(8'h12, 1'b0, "R6 sync set with one gate open");
      wr(8'h10, 1'b0, "R5 R6 pulse still issued, error stays");
      hw_reset("R6 phase b");
      wr(8'h02, 1'b0, "R6 sync set with no gates");

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule